// File: doc/BRIEF.md
# Cache Block Management Operation Unit

This unit carries out one decoded cache-block management request at a time: flush, invalidate, or zero. The request brings an operation code, the raw address operand taken from a register, and a configuration bit that can turn an invalidate into a flush. The unit works out the cache block that holds the operand, whatever the operand's offset inside that block, and drives a simple command port towards the cache. A flush or an invalidate is a single command. A zero is a run of write beats, each with zero data, that together cover the whole block.

The cache answers each command with one response that either succeeds or names a fault class. On success the unit pulses `done`. On a fault it stops at once and pulses `fault`. With the fault it gives a cause code and a trap value, which is the operand exactly as it was received and not the block base.

The state machine has five named states. ST_IDLE accepts a request (IDLE->ISSUE on req_valid). ST_ISSUE presents a command (ISSUE->WAIT on cmd_ready). ST_WAIT waits for the response. From there, WAIT->FAULT on a faulting response, WAIT->ISSUE on success when zero beats remain, and WAIT->DONE on success for the last command. ST_DONE and ST_FAULT each last one cycle and return to ST_IDLE.

Top module: `cbm_op_unit`

## Requirements
- R1: A flush or invalidate command carries the operand with its low log2(BLOCK_BYTES) bits (6 by default) cleared.
- R2: An operand at any offset inside its block is legal. It ends with `done` and never with a unit-raised fault.
- R3: While `fault` is high, `trap_val` equals the unmodified operand of the request that faulted.
- R4: Command kinds are 0 for flush, 1 for invalidate and 2 for a zero write. Request codes are 0 for flush, 1 for invalidate and 2 for zero. An invalidate request with `cfg_inval_as_flush`=1 issues kind 0, and with 0 issues kind 1.
- R5: A zero request issues BLOCK_BYTES/BEAT_BYTES beats (8 by default) of kind 2, at block base + 8*i for i = 0..7 in order. Every beat has `cmd_strb` all ones and `cmd_data` zero, so together the beats cover the whole block.
- R6: A response with `rsp_fault` non-zero (1 page, 2 guest page, 3 access) raises `fault` for one cycle, in the cycle after the response. `fault_cause` equals that code, and no further command is issued for the request.
- R7: `req_ready` is high only in ST_IDLE. A request held valid while an operation runs is not accepted until after `done` or `fault`.
- R8: A flush or invalidate issues exactly one command and pulses `done` for one cycle, in the cycle after its successful response.
- R9: After reset, `req_ready` is 1 and `cmd_valid`, `done` and `fault` are 0.
- R10: While `cmd_valid` is high and `cmd_ready` low, the command address and kind hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit idle, request taken |
| req_op | input | 2 | 0 flush, 1 invalidate, 2 zero |
| req_addr | input | ADDR_W | Raw address operand |
| cfg_inval_as_flush | input | 1 | Run invalidate as flush |
| cmd_valid | output | 1 | Command present |
| cmd_ready | input | 1 | Cache takes command |
| cmd_kind | output | 2 | 0 flush, 1 invalidate, 2 zero write |
| cmd_addr | output | ADDR_W | Block or beat address |
| cmd_data | output | 8*BEAT_BYTES | Write data (always zero) |
| cmd_strb | output | BEAT_BYTES | Byte strobes |
| rsp_valid | input | 1 | Response for the outstanding command |
| rsp_fault | input | 2 | 0 ok, 1 page, 2 guest page, 3 access |
| done | output | 1 | Operation completed (pulse) |
| fault | output | 1 | Operation faulted (pulse) |
| fault_cause | output | 2 | Fault class while fault is high |
| trap_val | output | ADDR_W | Original operand while fault is high |

## Verification
The hardest situation to reach is a fault on a middle beat of a zero fill. The bench has to confirm that the unit stops there, issues no later beats, and still reports the unaligned operand rather than the address of that beat. The bench responder counts the beats of each request and injects a chosen fault code on a chosen beat index: the first, a middle one and the last. It also stalls `cmd_ready` on a fixed pattern, so that commands wait and responses arrive with varying delays. A junk request stays valid all through every operation, which tests that nothing is accepted until the unit returns to idle.

// File: rtl/cbm_pkg.sv
package cbm_pkg;
    typedef enum logic [1:0] {
        OP_FLUSH = 2'd0,
        OP_INVAL = 2'd1,
        OP_ZERO  = 2'd2,
        OP_RSVD  = 2'd3
    } cbm_op_e;

    localparam logic [1:0] KIND_FLUSH = 2'd0;
    localparam logic [1:0] KIND_INVAL = 2'd1;
    localparam logic [1:0] KIND_ZERO  = 2'd2;
    localparam logic [1:0] RSP_OK     = 2'd0;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_ISSUE = 3'd1,
        ST_WAIT  = 3'd2,
        ST_DONE  = 3'd3,
        ST_FAULT = 3'd4
    } cbm_state_e;
endpackage

// File: rtl/cbm_kind_sel.sv
module cbm_kind_sel
    import cbm_pkg::*;
(
    input  logic [1:0] op,
    input  logic       inval_as_flush,
    output logic [1:0] kind
);
    always_comb begin
        unique case (cbm_op_e'(op))
            OP_INVAL: kind = inval_as_flush ? KIND_FLUSH : KIND_INVAL;
            OP_ZERO:  kind = KIND_ZERO;
            default:  kind = KIND_FLUSH;
        endcase
    end
endmodule

// File: rtl/cbm_addr_gen.sv
module cbm_addr_gen #(
    parameter int ADDR_W      = 64,
    parameter int BLOCK_BYTES = 64,
    parameter int BEAT_BYTES  = 8,
    parameter int IDX_W       = 3
) (
    input  logic [ADDR_W-1:0] operand,
    input  logic [IDX_W-1:0]  beat_idx,
    output logic [ADDR_W-1:0] beat_addr
);
    localparam int BEAT_SH = $clog2(BEAT_BYTES);
    localparam logic [ADDR_W-1:0] OFF_MASK = ADDR_W'(BLOCK_BYTES - 1);

    logic [ADDR_W-1:0] base;
    assign base      = operand & ~OFF_MASK;
    assign beat_addr = base | (ADDR_W'(beat_idx) << BEAT_SH);
endmodule

// File: rtl/cbm_beat_ctr.sv
module cbm_beat_ctr #(
    parameter int BEATS = 8,
    parameter int IDX_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    output logic [IDX_W-1:0] idx,
    output logic             last
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(BEATS - 1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      idx <= '0;
        else if (clr)    idx <= '0;
        else if (inc)    idx <= idx + 1'b1;
    end

    assign last = (idx == LAST_IDX);
endmodule

// File: rtl/cbm_op_unit.sv
module cbm_op_unit
    import cbm_pkg::*;
#(
    parameter int ADDR_W      = 64,
    parameter int BLOCK_BYTES = 64,
    parameter int BEAT_BYTES  = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req_valid,
    output logic                    req_ready,
    input  logic [1:0]              req_op,
    input  logic [ADDR_W-1:0]       req_addr,
    input  logic                    cfg_inval_as_flush,
    output logic                    cmd_valid,
    input  logic                    cmd_ready,
    output logic [1:0]              cmd_kind,
    output logic [ADDR_W-1:0]       cmd_addr,
    output logic [8*BEAT_BYTES-1:0] cmd_data,
    output logic [BEAT_BYTES-1:0]   cmd_strb,
    input  logic                    rsp_valid,
    input  logic [1:0]              rsp_fault,
    output logic                    done,
    output logic                    fault,
    output logic [1:0]              fault_cause,
    output logic [ADDR_W-1:0]       trap_val
);
    localparam int BEATS = BLOCK_BYTES / BEAT_BYTES;
    localparam int IDX_W = (BEATS > 1) ? $clog2(BEATS) : 1;

    cbm_state_e         st_q, st_d;
    logic [ADDR_W-1:0]  opnd_q;
    logic [1:0]         kind_q;
    logic [1:0]         cause_q;
    logic [1:0]         kind_new;
    logic [IDX_W-1:0]   beat_idx;
    logic               beat_last;
    logic [ADDR_W-1:0]  beat_addr;
    logic               accept;
    logic               rsp_ok;
    logic               rsp_bad;

    assign accept  = (st_q == ST_IDLE) && req_valid;
    assign rsp_ok  = (st_q == ST_WAIT) && rsp_valid && (rsp_fault == RSP_OK);
    assign rsp_bad = (st_q == ST_WAIT) && rsp_valid && (rsp_fault != RSP_OK);

    cbm_kind_sel u_sel (
        .op             (req_op),
        .inval_as_flush (cfg_inval_as_flush),
        .kind           (kind_new)
    );

    cbm_beat_ctr #(.BEATS(BEATS), .IDX_W(IDX_W)) u_ctr (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (accept),
        .inc   (rsp_ok && (kind_q == KIND_ZERO) && !beat_last),
        .idx   (beat_idx),
        .last  (beat_last)
    );

    cbm_addr_gen #(
        .ADDR_W(ADDR_W), .BLOCK_BYTES(BLOCK_BYTES),
        .BEAT_BYTES(BEAT_BYTES), .IDX_W(IDX_W)
    ) u_agen (
        .operand   (opnd_q),
        .beat_idx  ((kind_q == KIND_ZERO) ? beat_idx : '0),
        .beat_addr (beat_addr)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // request and fault capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            opnd_q  <= '0;
            kind_q  <= KIND_FLUSH;
            cause_q <= RSP_OK;
        end else begin
            if (accept) begin
                opnd_q <= req_addr;
                kind_q <= kind_new;
            end
            if (rsp_bad) cause_q <= rsp_fault;
        end
    end

    // next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:  if (req_valid) st_d = ST_ISSUE;
            ST_ISSUE: if (cmd_ready) st_d = ST_WAIT;
            ST_WAIT: begin
                if (rsp_bad)
                    st_d = ST_FAULT;
                else if (rsp_ok)
                    st_d = ((kind_q == KIND_ZERO) && !beat_last) ? ST_ISSUE : ST_DONE;
            end
            ST_DONE:  st_d = ST_IDLE;
            ST_FAULT: st_d = ST_IDLE;
            default:  st_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        req_ready   = 1'b0;
        cmd_valid   = 1'b0;
        done        = 1'b0;
        fault       = 1'b0;
        fault_cause = RSP_OK;
        trap_val    = '0;
        unique case (st_q)
            ST_IDLE:  req_ready = 1'b1;
            ST_ISSUE: cmd_valid = 1'b1;
            ST_WAIT:  ;
            ST_DONE:  done = 1'b1;
            ST_FAULT: begin
                fault       = 1'b1;
                fault_cause = cause_q;
                trap_val    = opnd_q;
            end
            default:  ;
        endcase
        cmd_kind = kind_q;
        cmd_addr = beat_addr;
        cmd_data = '0;
        cmd_strb = (kind_q == KIND_ZERO) ? '1 : '0;
    end
endmodule

// File: rtl/cbm_op_unit_chk.sv
module cbm_op_unit_chk #(
    parameter int ADDR_W      = 64,
    parameter int BLOCK_BYTES = 64,
    parameter int BEAT_BYTES  = 8
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    req_valid,
    input logic                    req_ready,
    input logic [ADDR_W-1:0]       req_addr,
    input logic                    cmd_valid,
    input logic                    cmd_ready,
    input logic [1:0]              cmd_kind,
    input logic [ADDR_W-1:0]       cmd_addr,
    input logic [8*BEAT_BYTES-1:0] cmd_data,
    input logic [BEAT_BYTES-1:0]   cmd_strb,
    input logic                    rsp_valid,
    input logic [1:0]              rsp_fault,
    input logic                    done,
    input logic                    fault,
    input logic [ADDR_W-1:0]       trap_val
);
    localparam logic [ADDR_W-1:0] OFF_MASK = ADDR_W'(BLOCK_BYTES - 1);

    logic [ADDR_W-1:0] seen_opnd;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                      seen_opnd <= '0;
        else if (req_valid && req_ready) seen_opnd <= req_addr;
    end

    p_align_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_kind != 2'd2) |-> ((cmd_addr & OFF_MASK) == '0));

    p_trap_raw_r3: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> (trap_val == seen_opnd));

    p_zero_beat_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_kind == 2'd2) |-> ((&cmd_strb) && cmd_data == '0));

    p_fault_stop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault != 2'd0 && !req_ready && !cmd_valid && !done && !fault)
        |=> (fault && !cmd_valid));

    p_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (!cmd_valid && !done && !fault));

    p_one_end_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && fault));

    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_addr) && $stable(cmd_kind)));
endmodule

bind cbm_op_unit cbm_op_unit_chk #(
    .ADDR_W(ADDR_W), .BLOCK_BYTES(BLOCK_BYTES), .BEAT_BYTES(BEAT_BYTES)
) u_chk (.*);

// File: tb/sim_cbm_op_unit.sv
module sim_cbm_op_unit;
    localparam int AW    = 64;
    localparam int BLK   = 64;
    localparam int BEAT  = 8;
    localparam int BEATS = BLK / BEAT;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [1:0]    req_op = 2'd0;
    logic [AW-1:0] req_addr = '0;
    logic          cfg_inval_as_flush = 1'b0;
    logic          cmd_valid;
    logic          cmd_ready = 1'b0;
    logic [1:0]    cmd_kind;
    logic [AW-1:0] cmd_addr;
    logic [63:0]   cmd_data;
    logic [7:0]    cmd_strb;
    logic          rsp_valid = 1'b0;
    logic [1:0]    rsp_fault = 2'd0;
    logic          done;
    logic          fault;
    logic [1:0]    fault_cause;
    logic [AW-1:0] trap_val;

    cbm_op_unit #(.ADDR_W(AW), .BLOCK_BYTES(BLK), .BEAT_BYTES(BEAT)) u0 (.*);

    always #4 clk = ~clk;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // fault injection control, set by the stimulus before each request
    int inj_beat = -1;
    logic [1:0] inj_code = 2'd0;

    // reference model and responder state
    int            m_st = 0;
    int            m_beat = 0;
    logic [AW-1:0] m_addr = '0;
    logic [1:0]    m_kind = 2'd0;
    logic [1:0]    m_cause = 2'd0;
    logic [7:0]    covered = '0;
    bit            pend = 0;
    int            dly = 0;
    int            beat_no = 0;
    int            cyc = 0;
    logic          p_req_valid = 0, p_req_ready = 0, p_cfg = 0;
    logic [1:0]    p_op = 0, p_rsp_fault = 0;
    logic [AW-1:0] p_req_addr = 0, p_cmd_addr = 0;
    logic          p_cmd_valid = 0, p_cmd_ready = 0, p_rsp_valid = 0;
    logic [1:0]    p_cmd_kind = 0;

    always @(negedge clk) begin
        cyc++;
        if (!rst_n) begin
            m_st = 0; pend = 0; beat_no = 0;
            check(req_ready === 1'b1, "R9 req_ready", {63'd0, req_ready}, 64'd1);
            check(cmd_valid === 1'b0 && done === 1'b0 && fault === 1'b0, "R9 idle outputs",
                  {61'd0, cmd_valid, done, fault}, 64'd0);
        end else begin
            // responder bookkeeping for the edge just passed
            if (p_cmd_valid && p_cmd_ready) begin
                pend = 1; dly = cyc % 2;
                if (p_cmd_kind == 2'd2 && (p_cmd_addr - (m_addr & ~64'h3f)) < 64)
                    covered[(p_cmd_addr - (m_addr & ~64'h3f)) >> 3] = 1'b1;
            end else if (p_rsp_valid) begin
                pend = 0; beat_no++;
            end else if (pend && dly > 0) dly--;

            // reference model step
            case (m_st)
                0: if (p_req_valid) begin
                    m_addr = p_req_addr; m_beat = 0; covered = '0; beat_no = 0;
                    m_kind = (p_op == 2'd1 && p_cfg) ? 2'd0 : (p_op == 2'd3 ? 2'd0 : p_op);
                    m_st = 1;
                end
                1: if (p_cmd_ready) m_st = 2;
                2: if (p_rsp_valid) begin
                    if (p_rsp_fault != 2'd0) begin m_cause = p_rsp_fault; m_st = 4; end
                    else if (m_kind == 2'd2 && m_beat < BEATS - 1) begin m_beat++; m_st = 1; end
                    else m_st = 3;
                end
                default: m_st = 0;
            endcase

            // compare against the model
            check(req_ready === (m_st == 0), "R7 req_ready", {63'd0, req_ready}, {63'd0, m_st == 0});
            check(cmd_valid === (m_st == 1), "R8 cmd_valid", {63'd0, cmd_valid}, {63'd0, m_st == 1});
            if (m_st == 1) begin
                check(cmd_kind === m_kind, "R4 cmd_kind", {62'd0, cmd_kind}, {62'd0, m_kind});
                if (m_kind == 2'd2) begin
                    check(cmd_addr === (m_addr & ~64'h3f) + 64'(m_beat * 8), "R5 beat addr",
                          cmd_addr, (m_addr & ~64'h3f) + 64'(m_beat * 8));
                    check(cmd_strb === 8'hff && cmd_data === 64'd0, "R5 strobe/data",
                          {cmd_strb, cmd_data[55:0]}, {8'hff, 56'd0});
                end else begin
                    check(cmd_addr === (m_addr & ~64'h3f), "R1 aligned addr", cmd_addr, m_addr & ~64'h3f);
                end
                if (p_cmd_valid && !p_cmd_ready)
                    check(cmd_addr === p_cmd_addr && cmd_kind === p_cmd_kind, "R10 hold", cmd_addr, p_cmd_addr);
            end
            check(done === (m_st == 3), "R2 done", {63'd0, done}, {63'd0, m_st == 3});
            check(fault === (m_st == 4), "R6 fault", {63'd0, fault}, {63'd0, m_st == 4});
            if (m_st == 4) begin
                check(fault_cause === m_cause, "R6 cause", {62'd0, fault_cause}, {62'd0, m_cause});
                check(trap_val === m_addr, "R3 trap_val", trap_val, m_addr);
            end
            if (m_st == 3 && m_kind == 2'd2)
                check(covered == 8'hff, "R5 block coverage", {56'd0, covered}, 64'hff);
        end

        // drive responder inputs for the next edge
        cmd_ready = rst_n && ((cyc % 3) != 1);
        rsp_valid = rst_n && pend && (dly == 0);
        rsp_fault = (rsp_valid && beat_no == inj_beat) ? inj_code : 2'd0;

        p_req_valid = req_valid; p_req_ready = req_ready; p_op = req_op;
        p_req_addr = req_addr; p_cfg = cfg_inval_as_flush;
        p_cmd_valid = cmd_valid; p_cmd_ready = cmd_ready; p_cmd_addr = cmd_addr;
        p_cmd_kind = cmd_kind; p_rsp_valid = rsp_valid; p_rsp_fault = rsp_fault;
    end

    task automatic run_req(input logic [1:0] op, input logic [AW-1:0] addr, input logic cfg,
                           input int fbeat, input logic [1:0] fcode);
        @(posedge clk); #2;
        inj_beat = fbeat; inj_code = fcode;
        req_op = op; req_addr = addr; cfg_inval_as_flush = cfg; req_valid = 1'b1;
        forever begin
            @(negedge clk);
            if (req_ready) break;
        end
        @(posedge clk); #2;
        // junk request stays valid while busy (R7)
        req_op = 2'd2; req_addr = 64'hdead_beef_0000_0013; cfg_inval_as_flush = ~cfg;
        forever begin
            @(negedge clk);
            if (done || fault) break;
        end
        @(posedge clk); #2;
        req_valid = 1'b0;
        repeat (2) @(posedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #2 rst_n = 1'b1;
        run_req(2'd0, 64'h0000_0000_0000_1000, 1'b0, -1, 2'd0);   // R1 R8 aligned flush
        run_req(2'd0, 64'h0000_0000_0000_1237, 1'b0, -1, 2'd0);   // R2 unaligned flush
        run_req(2'd1, 64'h0000_0000_0000_2fff, 1'b0, -1, 2'd0);   // R4 invalidate kept
        run_req(2'd1, 64'h0000_0000_0000_3041, 1'b1, -1, 2'd0);   // R4 invalidate as flush
        run_req(2'd2, 64'h0000_0000_0000_4005, 1'b0, -1, 2'd0);   // R5 zero unaligned
        run_req(2'd2, 64'h0000_0000_0000_8000, 1'b1, -1, 2'd0);   // R5 zero aligned
        run_req(2'd2, 64'h0000_0000_0000_5123, 1'b0, 3, 2'd1);    // R6 mid-beat page fault
        run_req(2'd2, 64'h0000_0000_0000_5a7f, 1'b0, 0, 2'd2);    // R6 first beat
        run_req(2'd2, 64'h0000_0000_0000_5fc9, 1'b0, 7, 2'd3);    // R6 last beat
        run_req(2'd0, 64'h0000_0000_0000_6abc, 1'b0, 0, 2'd3);    // R3 flush access fault
        run_req(2'd1, 64'h7fff_ffff_ffff_ffc1, 1'b1, 0, 2'd2);    // R3 R4 inval-as-flush fault
        run_req(2'd0, 64'hffff_ffff_ffff_ffff, 1'b0, -1, 2'd0);   // R1 top of space
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule